// File: doc/BRIEF.md
# Instruction Fetch Cache with Selectable Replacement

This block sits between a processor's instruction fetch port and a word-wide main-memory read port. It holds recently fetched code in a small set-associative store: 4 ways and 4 sets, with lines of 8 words. When the cache is enabled, a fetch marked cacheable that finds its line returns the word one cycle after it is accepted and makes no memory access. A cacheable fetch that misses loads the whole aligned 8-word line from memory. The line is read starting at the requested word, and the following words wrap around inside the line. The requested word goes back to the processor as soon as it arrives. The fetch port stays stalled until the last word of the line has been written.

A fetch marked non-cacheable, and any fetch made while the cache is disabled, is served by a single memory read of exactly that word. Neither kind of fetch allocates a line. The tag lookup still runs on every fetch while the cache is enabled, but the result is used only when the fetch is cacheable.

A level input selects the victim policy when a set is full. One setting uses a round-robin pointer kept for each set. The other uses a free-running LFSR. In both cases an empty way is always taken before the policy is consulted. An invalidate-all pulse clears every valid bit at once. If it arrives during a fill, that line is not installed.

Top module: `ifetch_cache`

## Requirements
- R1: While reset is held and on the first cycle after it, the fetch port is ready (`fetch_ready`=1), no response is issued and no memory read is requested. No line is valid, so the first enabled cacheable fetch misses.
- R2: While `cfg_enable`=0, each fetch causes exactly one memory read at the fetch address, returns that word, and installs nothing. A later enabled cacheable fetch to the same line therefore misses.
- R3: An enabled cacheable fetch that misses issues exactly 8 memory reads. Their addresses keep the line bits (address bits above bit 2) of the fetch and take offsets (bits 2:0) of o, o+1, … modulo 8, where o is the offset of the fetch. The line is then installed.
- R4: During a fill, the requested word is returned on `rsp_data` in the cycle after its memory response arrives, and only one memory response has arrived by then. `fetch_ready` stays 0 until the eighth word has been received.
- R5: An enabled cacheable fetch that hits raises `rsp_valid` with the stored word in the next cycle and causes no memory read.
- R6: An enabled fetch with `fetch_cacheable`=0 causes exactly one memory read of its own word, even when the line is resident, and installs nothing.
- R7: When the indexed set (address bits 4:3) has an invalid way, the fill goes to the lowest-numbered invalid way, whatever the policy selects.
- R8: With `cfg_rr_mode`=1 and the set full, the victim is the way given by that set's 2-bit pointer. Every pointer is 0 after reset and advances by one (modulo 4) each time a line is installed in its set.
- R9: With `cfg_rr_mode`=0 and the set full, the victim is taken from a free-running LFSR at the moment the miss is accepted. Exactly the new line becomes resident, and it then hits.
- R10: A one-cycle `inv_all` clears every valid bit by the next cycle. If it is raised while a fill is in progress, that fill still returns its word but does not install the line and does not advance the pointer.
- R11: A memory read request (`mem_req_valid`) stays raised with a constant address until `mem_req_ready` accepts it, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | 1 enables the cache, 0 sends every fetch to memory |
| cfg_rr_mode | input | 1 | Victim policy: 1 round-robin, 0 pseudo-random |
| inv_all | input | 1 | One-cycle pulse that invalidates every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch accepted when high together with `fetch_valid` |
| fetch_addr | input | AW (16) | Word address of the fetch |
| fetch_cacheable | input | 1 | Fetch may be served from and allocated in the cache |
| rsp_valid | output | 1 | One-cycle strobe carrying the fetched word |
| rsp_data | output | DW (32) | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW (16) | Word address to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | DW (32) | Read data |

## Verification
The checker watches, on every cycle, the properties that need no memory of earlier traffic. These are: a hit responds in the next cycle without touching memory; a bypass fetch always raises a memory request; the fetch port is blocked while a fill runs; the critical word appears right after its arrival; a free way wins over the policy; the memory request is held steady; and invalidate-all empties the valid bits. The bench's scenarios are needed for the properties that depend on history. These are: the exact wrap order of fill addresses; the absence of allocation after bypass reads; which line the round-robin pointer evicts after several fills; the cancelling of a fill by an invalidate pulse in the middle of the fill; and the correctness of every returned word, with randomly throttled memory timing.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ifc_state_e;

  localparam int LFSR_W = 8;

  // x^8 + x^6 + x^5 + x^4 + 1, shifting toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/ifc_lfsr.sv
`timescale 1ns/1ps
module ifc_lfsr
  import ifc_pkg::*;
#(
  parameter int OUT_W = 2,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick_o
);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= lfsr_step(state_q);
  end

  assign pick_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/ifc_tags.sv
`timescale 1ns/1ps
module ifc_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int TAG_W = 11,
  localparam int WB   = $clog2(WAYS),
  localparam int SB   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SB-1:0]    lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             rr_mode,
  input  logic [WB-1:0]    rnd_way,
  input  logic             inv_all,
  input  logic             wr_en,
  input  logic [SB-1:0]    wr_set,
  input  logic [WB-1:0]    wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             lk_hit,
  output logic [WB-1:0]    lk_way,
  output logic [WB-1:0]    vic_way,
  output logic             vic_valid,
  output logic             set_free,
  output logic             any_valid
);

  logic [SETS-1:0]  vld   [WAYS];
  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [WB-1:0]    ptr   [SETS];
  logic [WAYS-1:0]  way_hit;
  logic [WAYS-1:0]  way_free;
  logic [WB-1:0]    free_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w]  = vld[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    assign way_free[w] = !vld[w][lk_set];
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (!rst_n || inv_all) vld[w] <= '0;
      else if (wr_en && wr_way == WB'(w)) vld[w][wr_set] <= 1'b1;
      if (wr_en && wr_way == WB'(w)) tag_q[w][wr_set] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (wr_en) begin
      ptr[wr_set] <= ptr[wr_set] + WB'(1);
    end
  end

  // lowest index wins for both the hit and the free-way encoders
  always_comb begin
    lk_way   = '0;
    free_way = '0;
    set_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) lk_way = WB'(i);
      if (way_free[i]) begin
        free_way = WB'(i);
        set_free = 1'b1;
      end
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int w = 0; w < WAYS; w++) any_valid = any_valid | (|vld[w]);
  end

  assign lk_hit    = |way_hit;
  assign vic_way   = set_free ? free_way : (rr_mode ? ptr[lk_set] : rnd_way);
  assign vic_valid = vld[vic_way][lk_set];

endmodule

// File: rtl/ifc_data.sv
`timescale 1ns/1ps
module ifc_data #(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int WB   = $clog2(WAYS),
  localparam int SB   = $clog2(SETS),
  localparam int OB   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [WB-1:0] wr_way,
  input  logic [SB-1:0] wr_set,
  input  logic [OB-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [WB-1:0] rd_way,
  input  logic [SB-1:0] rd_set,
  input  logic [OB-1:0] rd_off,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = WAYS * SETS * WORDS;
  localparam int IW    = WB + SB + OB;

  logic [DW-1:0] store [DEPTH];

  function automatic logic [IW-1:0] slot(input logic [WB-1:0] w,
                                         input logic [SB-1:0] s,
                                         input logic [OB-1:0] o);
    return {w, s, o};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) store[slot(wr_way, wr_set, wr_off)] <= wr_data;
  end

  assign rd_data = store[slot(rd_way, rd_set, rd_off)];

endmodule

// File: rtl/ifetch_cache.sv
`timescale 1ns/1ps
module ifetch_cache
  import ifc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_rr_mode,
  input  logic          inv_all,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_cacheable,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int WB    = $clog2(WAYS);
  localparam int SB    = $clog2(SETS);
  localparam int OB    = $clog2(LINE_WORDS);
  localparam int TAG_W = AW - SB - OB;
  localparam logic [OB-1:0] LAST_CNT = OB'(LINE_WORDS - 1);

  function automatic logic [OB-1:0] a_off(input logic [AW-1:0] a);
    return a[OB-1:0];
  endfunction
  function automatic logic [SB-1:0] a_set(input logic [AW-1:0] a);
    return a[OB +: SB];
  endfunction
  function automatic logic [TAG_W-1:0] a_tag(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction
  // next word of the same line, wrapping inside it
  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return {a[AW-1:OB], a[OB-1:0] + OB'(1)};
  endfunction

  ifc_state_e       state;
  logic [AW-1:0]    cur_addr;
  logic             is_fill;
  logic             fill_kill;
  logic [OB-1:0]    cnt;
  logic [WB-1:0]    fill_way;
  logic [SB-1:0]    fill_set;
  logic [TAG_W-1:0] fill_tag;

  // named events for the checker
  logic          accept, hit_take, fill_go, byp_go;
  logic          word_in, first_word, fill_done, commit, fill_busy;
  logic          lookup_hit, set_free, vic_valid, any_valid;
  logic [WB-1:0] lk_way, vic_way, rnd_way;
  logic [DW-1:0] hit_data;

  assign accept     = fetch_valid && (state == ST_IDLE);
  assign hit_take   = accept && cfg_enable && fetch_cacheable && lookup_hit;
  assign fill_go    = accept && cfg_enable && fetch_cacheable && !lookup_hit;
  assign byp_go     = accept && !(cfg_enable && fetch_cacheable);
  assign word_in    = (state == ST_WAIT) && mem_rsp_valid;
  assign first_word = (cnt == '0);
  assign fill_done  = word_in && is_fill && (cnt == LAST_CNT);
  assign commit     = fill_done && !fill_kill && !inv_all;
  assign fill_busy  = is_fill && (state != ST_IDLE);

  ifc_lfsr #(.OUT_W(WB)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pick_o (rnd_way)
  );

  ifc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (a_set(fetch_addr)),
    .lk_tag    (a_tag(fetch_addr)),
    .rr_mode   (cfg_rr_mode),
    .rnd_way   (rnd_way),
    .inv_all   (inv_all),
    .wr_en     (commit),
    .wr_set    (fill_set),
    .wr_way    (fill_way),
    .wr_tag    (fill_tag),
    .lk_hit    (lookup_hit),
    .lk_way    (lk_way),
    .vic_way   (vic_way),
    .vic_valid (vic_valid),
    .set_free  (set_free),
    .any_valid (any_valid)
  );

  ifc_data #(.WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .DW(DW)) u_data (
    .clk     (clk),
    .wr_en   (word_in && is_fill),
    .wr_way  (fill_way),
    .wr_set  (fill_set),
    .wr_off  (a_off(cur_addr)),
    .wr_data (mem_rsp_data),
    .rd_way  (lk_way),
    .rd_set  (a_set(fetch_addr)),
    .rd_off  (a_off(fetch_addr)),
    .rd_data (hit_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      is_fill   <= 1'b0;
      fill_kill <= 1'b0;
      cnt       <= '0;
      fill_way  <= '0;
      fill_set  <= '0;
      fill_tag  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (inv_all && fill_busy) fill_kill <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (hit_take) begin
            rsp_valid <= 1'b1;
            rsp_data  <= hit_data;
          end else if (fill_go || byp_go) begin
            state     <= ST_REQ;
            cur_addr  <= fetch_addr;
            is_fill   <= fill_go;
            fill_kill <= 1'b0;
            cnt       <= '0;
            fill_way  <= vic_way;
            fill_set  <= a_set(fetch_addr);
            fill_tag  <= a_tag(fetch_addr);
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (first_word) begin
              rsp_valid <= 1'b1;
              rsp_data  <= mem_rsp_data;
            end
            if (!is_fill || cnt == LAST_CNT) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_REQ;
              cnt      <= cnt + OB'(1);
              cur_addr <= next_word(cur_addr);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready   = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = cur_addr;

endmodule

// File: rtl/ifetch_cache_checks.sv
`timescale 1ns/1ps
module ifetch_cache_checks #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv_all,
  input logic          fetch_ready,
  input logic          rsp_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          hit_take,
  input logic          fill_go,
  input logic          byp_go,
  input logic          word_in,
  input logic          first_word,
  input logic          fill_busy,
  input logic          set_has_free,
  input logic          victim_valid,
  input logic          any_valid
);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> !any_valid && !mem_req_valid && fetch_ready && !rsp_valid); // R1

  AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_take |=> rsp_valid && !mem_req_valid); // R5

  AST_BYPASS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    byp_go |=> mem_req_valid && !fetch_ready); // R6

  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !fetch_ready); // R4

  AST_CRITICAL_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    word_in && first_word |=> rsp_valid); // R4

  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && set_has_free |-> !victim_valid); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11

  AST_INVALIDATE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid); // R10

endmodule

bind ifetch_cache ifetch_cache_checks #(.AW(AW)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .inv_all      (inv_all),
  .fetch_ready  (fetch_ready),
  .rsp_valid    (rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .hit_take     (hit_take),
  .fill_go      (fill_go),
  .byp_go       (byp_go),
  .word_in      (word_in),
  .first_word   (first_word),
  .fill_busy    (fill_busy),
  .set_has_free (set_free),
  .victim_valid (vic_valid),
  .any_valid    (any_valid)
);

// File: tb/ifetch_cache_test.sv
`timescale 1ns/1ps
module ifetch_cache_test;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LINE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b0;
  logic          cfg_rr_mode = 1'b1;
  logic          inv_all = 1'b0;
  logic          fetch_valid = 1'b0;
  logic          fetch_ready;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_cacheable = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  ifetch_cache uut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(input int a);
    logic [15:0] t;
    t = a[15:0];
    return {~t, t};
  endfunction

  // memory model: random acceptance, 1..3 cycles of latency
  int mem_reads = 0;
  int mem_rsps = 0;
  int req_log[$];
  initial begin
    bit pending;
    int lat;
    logic [AW-1:0] paddr;
    pending = 0;
    lat = 0;
    paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pending) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(int'(paddr));
          mem_rsps++;
          pending = 0;
        end else lat--;
      end
      mem_req_ready = !pending && (($urandom % 4) != 0);
      if (rst_n && mem_req_valid === 1'b1 && mem_req_ready) begin
        pending = 1;
        paddr = mem_req_addr;
        lat = $urandom % 3;
        mem_reads++;
        req_log.push_back(int'(mem_req_addr));
      end
    end
  end

  // reference model of the tag state
  bit mv[4][4];
  int mt[4][4];
  int mp[4];

  function automatic bit m_hit(input int a);
    int s = (a >> 3) & 3;
    int t = a >> 5;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) return 1;
    return 0;
  endfunction

  function automatic void m_install(input int a);
    int s = (a >> 3) & 3;
    int t = a >> 5;
    int v = -1;
    for (int w = 3; w >= 0; w--) if (!mv[s][w]) v = w;
    if (v < 0) begin
      if (cfg_rr_mode) v = mp[s];
      else begin
        for (int w = 0; w < 4; w++) mv[s][w] = 0;
        v = 0;
      end
    end
    mv[s][v] = 1;
    mt[s][v] = t;
    mp[s] = (mp[s] + 1) % 4;
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
  endfunction

  typedef struct {
    logic [DW-1:0] data;
    bit            fill;
    int            rsp_base;
    string         rq;
  } exp_t;
  exp_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5", "unexpected response", rsp_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_data == e.data, e.rq, "response data", rsp_data, e.data);
        if (e.fill) begin
          chk(fetch_ready == 1'b0, "R4", "port stalled at critical word", fetch_ready, 0);
          chk(mem_rsps - e.rsp_base == 1, "R4", "critical word latency (responses seen)",
              mem_rsps - e.rsp_base, 1);
        end
      end
    end
  end

  // driver
  task automatic fetch(input int a, input bit c, input int inv_after, input string rq);
    int n, base_r;
    bit fill, ok;
    exp_t e;
    fill = 0;
    if (!cfg_enable || !c) n = 1;
    else if (m_hit(a)) n = 0;
    else begin
      n = LINE;
      fill = 1;
    end
    e.data = mem_word(a);
    e.fill = fill;
    e.rsp_base = mem_rsps;
    e.rq = rq;
    exp_q.push_back(e);
    base_r = mem_reads;
    req_log.delete();
    while (!fetch_ready) begin
      @(negedge clk);
      #1;
    end
    fetch_valid = 1'b1;
    fetch_addr = AW'(a);
    fetch_cacheable = c;
    @(posedge clk);
    #1 fetch_valid = 1'b0;
    if (inv_after > 0) begin
      repeat (inv_after) @(negedge clk);
      #1 inv_all = 1'b1;
      @(negedge clk);
      #1 inv_all = 1'b0;
    end
    do begin
      @(negedge clk);
      #1;
    end while (!(fetch_ready && exp_q.size() == 0));
    chk(mem_reads - base_r == n, rq, "memory reads for fetch", mem_reads - base_r, n);
    if (fill) begin
      ok = (req_log.size() == LINE);
      for (int i = 0; i < LINE && ok; i++)
        if (req_log[i] != ((a & ~7) | ((a + i) & 7))) ok = 0;
      chk(ok, "R3", "fill address order", req_log.size(), LINE);
      if (inv_after > 0) m_clear();
      else m_install(a);
    end
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    #1 inv_all = 1'b1;
    @(negedge clk);
    #1 inv_all = 1'b0;
    m_clear();
  endtask

  function automatic int la(input int tag, input int set, input int off);
    return (tag << 5) | (set << 3) | off;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog: fetch port hung actual=stalled expected=ready");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_clear();
    for (int s = 0; s < 4; s++) mp[s] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(fetch_ready == 1'b1, "R1", "ready during reset", fetch_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(fetch_ready == 1'b1, "R1", "ready after reset", fetch_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "no memory request after reset", mem_req_valid, 0);

    // R2: disabled cache
    fetch(16'h0013, 1, 0, "R2");
    fetch(16'h0013, 1, 0, "R2");
    fetch(16'h0031, 0, 0, "R2");

    // R1, R3: first enabled fetch misses and fills with wrap
    cfg_enable = 1'b1;
    fetch(16'h0013, 1, 0, "R1");
    for (int i = 0; i < LINE; i++) fetch(16'h0010 + i, 1, 0, "R5");

    // R6: uncached fetches while enabled
    fetch(16'h0015, 0, 0, "R6");
    fetch(16'h0015, 1, 0, "R6");
    fetch(16'h0040, 0, 0, "R6");
    fetch(16'h0046, 1, 0, "R6");

    // R8: round-robin victims in set 1
    for (int t = 1; t <= 4; t++) fetch(la(t, 1, t), 1, 0, "R3");
    fetch(la(5, 1, 7), 1, 0, "R8");
    for (int t = 2; t <= 5; t++) fetch(la(t, 1, 0), 1, 0, "R8");
    fetch(la(1, 1, 2), 1, 0, "R8");
    fetch(la(2, 1, 2), 1, 0, "R8");
    fetch(la(4, 1, 6), 1, 0, "R8");

    // R7: free way preferred over the pointer in set 3
    fetch(la(1, 3, 0), 1, 0, "R7");
    fetch(la(2, 3, 0), 1, 0, "R7");
    fetch(la(3, 3, 0), 1, 0, "R7");
    fetch(la(1, 3, 5), 1, 0, "R7");

    // R10: invalidate-all, then during a fill
    pulse_inv();
    fetch(16'h0013, 1, 0, "R10");
    fetch(la(9, 2, 4), 1, 3, "R10");
    fetch(la(9, 2, 4), 1, 0, "R10");
    fetch(16'h0012, 1, 0, "R10");

    // R9: pseudo-random victim once set 0 is full
    cfg_rr_mode = 1'b0;
    pulse_inv();
    for (int t = 1; t <= 4; t++) fetch(la(t, 0, 3), 1, 0, "R9");
    for (int t = 1; t <= 4; t++) fetch(la(t, 0, 1), 1, 0, "R9");
    fetch(la(6, 0, 2), 1, 0, "R9");
    fetch(la(6, 0, 5), 1, 0, "R9");
    pulse_inv();
    cfg_rr_mode = 1'b1;

    // R2: disabling bypasses resident lines
    fetch(16'h0021, 1, 0, "R2");
    fetch(16'h0022, 1, 0, "R5");
    cfg_enable = 1'b0;
    fetch(16'h0022, 1, 0, "R2");
    cfg_enable = 1'b1;
    fetch(16'h0023, 1, 0, "R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule